// File: doc/BRIEF.md
# Trigger-Buffered Receive-Path Control Registers

This block sits behind a serial control slave in a receive-diversity switch. It keeps the power-mode/trigger register, a small trigger-assignment register and switch control register 0. Writes to register 0 can be held in a shadow copy and moved into the active copy only when software fires the trigger that register 0 is tied to. A trigger can also be masked, in which case writes go straight into the active copy.

The active register-0 value is decoded into enables for five receive paths. Outside normal power mode every path enable is held low, and the stored registers keep their contents. A write that selects the restore-defaults mode reloads every register and leaves the block in normal mode. A power-on reset or a software reset puts the block into low power mode with every register cleared.

The slave drives a one-cycle write strobe with an address and data, and reads through a combinational read port. Every write takes effect at the clock edge that samples it.

Top module: `rxsw_ctrl_regs`

## Requirements
- R1: After `rst` or `soft_rst`, address 0x1C reads 0x80 (mode 10 = low power, all masks 0), addresses 0x00 and 0x02 read 0x00, and all path enables are low.
- R2: Address 0x1C holds the power mode in bits 7:6 and the masks for triggers 2..0 in bits 5:3. Bits 2:0 are trigger strobes and always read as 0.
- R3: Register 0 is at address 0x00. When its assigned trigger is unmasked, a write to it changes only the shadow copy, so the read value of 0x00 and the path enables stay unchanged.
- R4: A write to register 0 reaches the active copy at the next edge if its assigned trigger's mask bit (bit 3+t of 0x1C) is set, or if the assignment value is 3 (not tied to any trigger).
- R5: Writing 0x1C with bit t set, while register 0 is assigned to trigger t, copies the shadow into the active copy. A strobe on any other trigger leaves the active copy unchanged.
- R6: Address 0x02 bits 1:0 hold register 0's trigger assignment: 0, 1 or 2 selects that trigger, and 3 means no trigger. It defaults to 0, and bits 7:2 read as 0.
- R7: In normal mode (00), active bit 0 drives `path_en[0]` (RX1), bit 1 drives `path_en[1]` (RX2), bit 3 drives `path_en[2]` (RX3), bit 2 drives `path_en[3]` (RX4) and bit 4 drives `path_en[4]` (RX5). Bits 7:5 have no effect, and all of bits 4:0 at zero turns every path off (isolation).
- R8: In mode 10 (low power) or mode 11 (reserved), all path enables are low while register 0 keeps its value. Returning to mode 00 restores the decoded paths.
- R9: Writing 0x1C with mode 01 clears register 0, its shadow, the masks and the assignment, and leaves the mode field at 00.
- R10: Reads of addresses other than 0x00, 0x02 and 0x1C return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst | input | 1 | Synchronous active-high software reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| path_en | output | 5 | Receive path enables, bit 0 = RX1 through bit 4 = RX5 |

## Verification
Every cycle, the assertions check the reset state of the mode and mask fields, the move of restore into normal mode, and the three write routes into register 0. The three routes are staged with the active copy held, direct, and committed from the shadow. The assertions also check that path enables stay low outside normal mode. Only the bench's scenarios can show the path bit mapping and that a strobe for an unrelated trigger is ignored. The same holds for the readback layouts, the full restore of all registers and the silence of unmapped addresses, which the bench checks against a reference model across random write sequences mixed with soft resets.

// File: rtl/rxsw_pkg.sv
package rxsw_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int NUM_TRIG = 3;
    localparam int NUM_PATH = 5;

    localparam logic [ADDR_W-1:0] ADDR_CTRL0   = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_TASSIGN = 5'h02;
    localparam logic [ADDR_W-1:0] ADDR_PMTRIG  = 5'h1C;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_RESTORE = 2'b01,
        PM_LOW     = 2'b10,
        PM_RSVD    = 2'b11
    } pmode_t;

    // Register-0 bit to receive path mapping (RX3 and RX4 are crossed).
    function automatic logic [NUM_PATH-1:0] path_map(input logic [4:0] r);
        logic [NUM_PATH-1:0] p;
        p[0] = r[0];
        p[1] = r[1];
        p[2] = r[3];
        p[3] = r[2];
        p[4] = r[4];
        return p;
    endfunction

endpackage

// File: rtl/rxsw_trig_ctrl.sv
module rxsw_trig_ctrl
    import rxsw_pkg::*;
#(
    parameter int N_TRIG = NUM_TRIG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              hit,
    input  logic [7:0]        wr_data,
    output pmode_t            mode_q,
    output logic [N_TRIG-1:0] mask_q,
    output logic [N_TRIG-1:0] strobe,
    output logic              restore
);

    logic wr_here;

    assign wr_here = wr_en && hit;
    assign restore = wr_here && (wr_data[7:6] == PM_RESTORE);
    assign strobe  = (wr_here && !restore) ? wr_data[N_TRIG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_LOW;
            mask_q <= '0;
        end else if (restore) begin
            mode_q <= PM_NORMAL;
            mask_q <= '0;
        end else if (wr_here) begin
            mode_q <= pmode_t'(wr_data[7:6]);
            mask_q <= wr_data[2*N_TRIG-1:N_TRIG];
        end
    end

    // R1: reset lands in low power with all masks cleared
    a_r1_reset_low_power: assert property (@(posedge clk)
        rst |=> (mode_q == PM_LOW) && (mask_q == '0));

    // R9: restore request ends in normal mode
    a_r9_restore_normal: assert property (@(posedge clk) disable iff (rst)
        restore |=> (mode_q == PM_NORMAL) && (mask_q == '0));

endmodule

// File: rtl/rxsw_shadow_reg.sv
module rxsw_shadow_reg #(
    parameter int              W         = 8,
    parameter int              N_TRIG    = 3,
    parameter logic [W-1:0]    RESET_VAL = '0,
    localparam int             SEL_W     = $clog2(N_TRIG + 1)
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_data,
    input  logic [SEL_W-1:0]  sel,
    input  logic [N_TRIG-1:0] mask,
    input  logic [N_TRIG-1:0] strobe,
    output logic [W-1:0]      active_q
);

    logic [W-1:0]      shadow_q;
    logic [N_TRIG-1:0] sel_hit;
    logic              direct;
    logic              commit;

    for (genvar t = 0; t < N_TRIG; t++) begin : g_sel
        assign sel_hit[t] = (sel == SEL_W'(t));
    end

    assign direct = ~|sel_hit || |(sel_hit & mask);
    assign commit = |(sel_hit & strobe);

    always_ff @(posedge clk) begin
        if (clr) begin
            shadow_q <= RESET_VAL;
            active_q <= RESET_VAL;
        end else if (wr_en) begin
            shadow_q <= wr_data;
            if (direct) active_q <= wr_data;
        end else if (commit) begin
            active_q <= shadow_q;
        end
    end

    // R3: a staged write leaves the active copy untouched
    a_r3_staged_hold: assert property (@(posedge clk) disable iff (clr)
        (wr_en && !direct) |=> $stable(active_q));

    // R4: a masked or unassigned write lands at once
    a_r4_direct_write: assert property (@(posedge clk) disable iff (clr)
        (wr_en && direct) |=> active_q == $past(wr_data));

    // R5: the assigned trigger copies the shadow across
    a_r5_trigger_commit: assert property (@(posedge clk) disable iff (clr)
        (commit && !wr_en) |=> active_q == $past(shadow_q));

endmodule

// File: rtl/rxsw_path_decode.sv
module rxsw_path_decode
    import rxsw_pkg::*;
(
    input  logic [4:0]          ctrl,
    input  pmode_t              mode,
    output logic [NUM_PATH-1:0] path_en
);

    always_comb begin
        path_en = '0;
        if (mode == PM_NORMAL) path_en = path_map(ctrl);
    end

endmodule

// File: rtl/rxsw_ctrl_regs.sv
module rxsw_ctrl_regs
    import rxsw_pkg::*;
#(
    parameter int N_TRIG = NUM_TRIG,
    localparam int SEL_W = $clog2(N_TRIG + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_PATH-1:0] path_en
);

    logic              any_rst;
    logic              clr_all;
    pmode_t            mode_q;
    logic [N_TRIG-1:0] mask_q;
    logic [N_TRIG-1:0] strobe;
    logic              restore;
    logic [SEL_W-1:0]  assign_q;
    logic [DATA_W-1:0] ctrl0_q;
    logic [DATA_W-1:0] pm_rd;

    assign any_rst = rst || soft_rst;
    assign clr_all = any_rst || restore;

    rxsw_trig_ctrl #(.N_TRIG(N_TRIG)) u_trig (
        .clk     (clk),
        .rst     (any_rst),
        .wr_en   (wr_en),
        .hit     (wr_addr == ADDR_PMTRIG),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .mask_q  (mask_q),
        .strobe  (strobe),
        .restore (restore)
    );

    always_ff @(posedge clk) begin
        if (clr_all) assign_q <= '0;
        else if (wr_en && wr_addr == ADDR_TASSIGN) assign_q <= wr_data[SEL_W-1:0];
    end

    rxsw_shadow_reg #(.W(DATA_W), .N_TRIG(N_TRIG), .RESET_VAL('0)) u_ctrl0 (
        .clk      (clk),
        .clr      (clr_all),
        .wr_en    (wr_en && wr_addr == ADDR_CTRL0),
        .wr_data  (wr_data),
        .sel      (assign_q),
        .mask     (mask_q),
        .strobe   (strobe),
        .active_q (ctrl0_q)
    );

    rxsw_path_decode u_dec (
        .ctrl    (ctrl0_q[4:0]),
        .mode    (mode_q),
        .path_en (path_en)
    );

    always_comb begin
        pm_rd = '0;
        pm_rd[7:6] = mode_q;
        pm_rd[2*N_TRIG-1:N_TRIG] = mask_q;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL0:   rd_data = ctrl0_q;
            ADDR_TASSIGN: rd_data[SEL_W-1:0] = assign_q;
            ADDR_PMTRIG:  rd_data = pm_rd;
            default:      rd_data = '0;
        endcase
    end

    // R8: no path enabled outside normal mode
    a_r8_paths_forced_off: assert property (@(posedge clk) disable iff (any_rst)
        (mode_q != PM_NORMAL) |-> (path_en == '0));

    // R9: restore empties register 0 and its assignment
    a_r9_restore_clears: assert property (@(posedge clk) disable iff (any_rst)
        restore |=> (ctrl0_q == '0) && (assign_q == '0));

endmodule

// File: tb/tb_rxsw_ctrl_regs.sv
module tb_rxsw_ctrl_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] path_en;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [1:0] m_mode;
    logic [2:0] m_mask;
    logic [1:0] m_asg;
    logic [7:0] m_act;
    logic [7:0] m_sh;

    always #4 clk = ~clk;

    rxsw_ctrl_regs dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .path_en(path_en)
    );

    function automatic logic [4:0] exp_paths(input logic [7:0] a, input logic [1:0] md);
        if (md != 2'b00) return 5'b0;
        return {a[4], a[2], a[3], a[1], a[0]};
    endfunction

    function automatic logic [7:0] exp_pm();
        return {m_mode, m_mask, 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic model_reset();
        m_mode = 2'b10; m_mask = '0; m_asg = '0; m_act = '0; m_sh = '0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            5'h00: begin
                m_sh = d;
                if (m_asg == 2'd3 || m_mask[m_asg]) m_act = d;
            end
            5'h02: m_asg = d[1:0];
            5'h1C: begin
                if (d[7:6] == 2'b01) begin
                    m_mode = 2'b00; m_mask = '0; m_asg = '0; m_act = '0; m_sh = '0;
                end else begin
                    if (m_asg != 2'd3 && d[m_asg]) m_act = m_sh;
                    m_mode = d[7:6];
                    m_mask = d[5:3];
                end
            end
            default: ;
        endcase
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        model_reset();
    endtask

    task automatic check_all(input string ctx);
        logic [7:0] d;
        rd(5'h00, d); chk({ctx, " R3 reg0"}, d, m_act);
        rd(5'h02, d); chk({ctx, " R6 assign"}, d, {6'b0, m_asg});
        rd(5'h1C, d); chk({ctx, " R2 pmtrig"}, d, exp_pm());
        chk({ctx, " R7 paths"}, {3'b0, path_en}, {3'b0, exp_paths(m_act, m_mode)});
    endtask

    initial begin
        #1_600_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h1C, d); chk("R1 pmtrig after reset", d, 8'h80);
        rd(5'h00, d); chk("R1 reg0 after reset", d, 8'h00);
        rd(5'h02, d); chk("R1 assign after reset", d, 8'h00);
        chk("R1 paths after reset", {3'b0, path_en}, 8'h00);

        // R2 normal mode
        wr(5'h1C, 8'h00);
        rd(5'h1C, d); chk("R2 mode normal", d, 8'h00);

        // R3 staged write
        wr(5'h00, 8'h03);
        rd(5'h00, d); chk("R3 staged reg0 unchanged", d, 8'h00);
        chk("R3 staged paths unchanged", {3'b0, path_en}, 8'h00);

        // R5 unrelated trigger, then the assigned one
        wr(5'h1C, 8'h02);
        rd(5'h00, d); chk("R5 other trigger ignored", d, 8'h00);
        rd(5'h1C, d); chk("R2 strobe reads zero", d, 8'h00);
        wr(5'h1C, 8'h01);
        rd(5'h00, d); chk("R5 commit reg0", d, 8'h03);
        chk("R5 commit paths", {3'b0, path_en}, 8'h03);

        // R4 masked write, R7 decode
        wr(5'h1C, 8'h08);
        rd(5'h1C, d); chk("R2 mask0 readback", d, 8'h08);
        wr(5'h00, 8'hE4);
        rd(5'h00, d); chk("R4 masked direct", d, 8'hE4);
        chk("R7 bit2 to RX4, bits7:5 ignored", {3'b0, path_en}, 8'h08);
        wr(5'h00, 8'h08);
        chk("R7 bit3 to RX3", {3'b0, path_en}, 8'h04);
        wr(5'h00, 8'h10);
        chk("R7 bit4 to RX5", {3'b0, path_en}, 8'h10);
        wr(5'h00, 8'h00);
        chk("R7 isolation", {3'b0, path_en}, 8'h00);

        // R6 assignment, R4 unassigned write
        wr(5'h02, 8'hFF);
        rd(5'h02, d); chk("R6 assign readback", d, 8'h03);
        wr(5'h1C, 8'h00);
        wr(5'h00, 8'h11);
        chk("R4 unassigned direct", {3'b0, path_en}, 8'h11);

        // R8 low power and reserved modes
        wr(5'h1C, 8'h80);
        chk("R8 low power off", {3'b0, path_en}, 8'h00);
        rd(5'h00, d); chk("R8 reg0 kept", d, 8'h11);
        wr(5'h1C, 8'hC0);
        chk("R8 reserved off", {3'b0, path_en}, 8'h00);
        wr(5'h1C, 8'h00);
        chk("R8 back to normal", {3'b0, path_en}, 8'h11);

        // R9 restore
        wr(5'h02, 8'h01);
        wr(5'h1C, 8'h10);
        wr(5'h00, 8'h05);
        wr(5'h1C, 8'h40);
        rd(5'h1C, d); chk("R9 mode 00 after restore", d, 8'h00);
        rd(5'h00, d); chk("R9 reg0 cleared", d, 8'h00);
        rd(5'h02, d); chk("R9 assign cleared", d, 8'h00);
        wr(5'h1C, 8'h01);
        rd(5'h00, d); chk("R9 shadow cleared", d, 8'h00);

        // R10 unmapped
        wr(5'h00, 8'h00);
        wr(5'h05, 8'hFF);
        rd(5'h05, d); chk("R10 unmapped read", d, 8'h00);
        check_all("R10 after unmapped write");

        // R1 soft reset
        wr(5'h02, 8'h03);
        wr(5'h00, 8'h1F);
        pulse_soft();
        rd(5'h1C, d); chk("R1 soft reset pmtrig", d, 8'h80);
        check_all("R1 soft reset");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 19);
            v = 8'($urandom);
            if (op < 7) wr(5'h00, v);
            else if (op < 9) wr(5'h02, v);
            else if (op < 17) begin
                if (v[7:6] == 2'b01 && $urandom_range(0, 3) != 0) v[7:6] = 2'b00;
                wr(5'h1C, v);
            end else if (op < 19) begin
                logic [4:0] a;
                a = 5'($urandom_range(3, 27));
                wr(a, v);
                rd(a, v); chk("R10 random unmapped read", v, 8'h00);
            end else pulse_soft();
            check_all("random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule